// File: doc/BRIEF.md
# Eight-Way Pseudo-LRU Victim Selector with Deferred Castout

This block chooses the replacement way for an eight-way set-associative cache. It also schedules the eviction of a modified victim line. For every set it keeps a seven-node binary decision tree. Each hit reported on the access port moves the nodes on that way's path so they lead away from the way. When the cache reports a miss, the block picks the way to fill. An empty way wins over the tree's choice. The chosen way is then treated as the most recent one in its set.

When the chosen way holds modified data, the cache hands that line to the block over the capture port. The block keeps it in a single line buffer while the refill read goes ahead. Only after the cache signals that the refill has finished does the buffer drain. It drains as a four-beat, 64-bit burst on a valid/ready write port. Only one miss may be outstanding at a time. A later miss whose victim is also modified waits until the buffer is empty again. The tag and data arrays, coherency and the memory behind the write port all live outside this block.

Top module: `plru_castout_ctrl`

## Requirements
- R1: After reset, `miss_ready` is high and `vic_valid` and `wb_valid` are low. Every set's tree is cleared, so the first victim of a set whose eight ways are all valid is way 0.
- R2: An access (`acc_valid`) to way w of a set sets the three tree nodes on w's path to point away from w. For example, accessing ways 0 to 7 in order leaves way 0 as the next victim.
- R3: When any bit of `miss_vmask` is 0 (bit i = way i holds a valid line), the victim is the lowest-numbered way whose bit is 0, whatever the tree holds.
- R4: When all eight bits of `miss_vmask` are 1, the victim is found by walking the tree from its root. A node value of 0 selects the lower half of the remaining ways and 1 selects the upper half. The three choices, most significant first, form the way number.
- R5: A miss is accepted when `miss_valid` and `miss_ready` are both high. In the next cycle `vic_valid` is high for exactly one cycle, with the chosen way on `vic_way`. From then on the tree of that set treats the chosen way as most recently used.
- R6: `vic_dirty` equals bit `vic_way` of both `miss_dmask` and `miss_vmask`. For a dirty victim, the first `cap_valid` after acceptance loads `cap_addr` and `cap_data` into the buffer. A `cap_valid` at any other time is ignored.
- R7: For a dirty victim, `wb_valid` stays low until both the capture and the refill completion (`refill_done`) have been seen. It rises in the cycle after the later of the two.
- R8: The burst is four beats. Beat k carries `cap_data[64k+63:64k]`, and every beat carries the captured address on `wb_addr`. `wb_last` is high on beat 3 only. A beat advances only on `wb_valid && wb_ready`, and otherwise all outputs hold. `wb_valid` falls after the last beat.
- R9: A clean victim never uses the buffer, and no burst follows it.
- R10: A miss whose victim is dirty is held off (`miss_ready` low) from the acceptance of a dirty miss until that miss's last beat is accepted. A miss with a clean victim is not held off by the buffer.
- R11: Only one miss is outstanding. `miss_ready` stays low from acceptance until `refill_done`.
- R12: Each set has its own tree. Accesses to one set do not change the victim chosen in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Hit access strobe |
| acc_set | input | 4 | Set of the access |
| acc_way | input | 3 | Way hit by the access |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Miss may be accepted this cycle |
| miss_set | input | 4 | Set of the miss |
| miss_vmask | input | 8 | Valid bit of each way of the missed set |
| miss_dmask | input | 8 | Modified bit of each way of the missed set |
| vic_valid | output | 1 | One-cycle pulse announcing the victim |
| vic_way | output | 3 | Chosen victim way |
| vic_dirty | output | 1 | Victim holds modified data |
| cap_valid | input | 1 | Victim line presented for capture |
| cap_addr | input | 32 | Line address of the victim |
| cap_data | input | 256 | Victim line data |
| refill_done | input | 1 | Refill of the outstanding miss completed |
| wb_valid | output | 1 | Burst beat valid |
| wb_ready | input | 1 | Downstream accepts the beat |
| wb_addr | output | 32 | Line address of the burst |
| wb_data | output | 64 | Beat data |
| wb_last | output | 1 | Final beat of the burst |

## Verification
The bench aims at the ordering of capture and refill completion. A design that drains as soon as the line is captured would show `wb_valid` while the refill is still pending. A design that drops a completion arriving before the capture would never drain at all. It also checks that empty ways win over the tree, and that one set's accesses leave another set's victim alone. A slip here shows up as a valid line being evicted, or as the wrong way in a set nobody touched. It presents dirty and clean misses while the buffer is draining under back-pressure. Wrong stall logic either accepts a second dirty line over the held one, or blocks clean misses for no reason. Stray capture pulses on an idle buffer must not corrupt the next burst.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Castout buffer sequencing
  typedef enum logic [1:0] {
    CB_IDLE      = 2'd0,  // buffer empty
    CB_WAIT_CAP  = 2'd1,  // dirty victim chosen, line not yet handed over
    CB_WAIT_LOAD = 2'd2,  // line held, refill still in flight
    CB_DRAIN     = 2'd3   // burst write in progress
  } cb_state_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/plru_touch.sv
// Marks one way as most recently used: every node on its path is set to
// lead away from it.
module plru_touch #(
  parameter  int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] state_i,
  input  logic [LVL-1:0]   way_i,
  output logic [NODES-1:0] state_o
);

  always_comb begin
    int idx;
    state_o = state_i;
    for (int l = 0; l < LVL; l++) begin
      idx = ((1 << l) - 1) + (int'(way_i) >> (LVL - l));
      state_o[idx] = ~way_i[LVL-1-l];
    end
  end

endmodule

// File: rtl/plru_walk.sv
// Follows the tree from the root to the least recently used leaf.
module plru_walk #(
  parameter  int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] state_i,
  output logic [LVL-1:0]   way_o
);

  always_comb begin
    int   node;
    logic dir;
    node  = 0;
    way_o = '0;
    for (int l = 0; l < LVL; l++) begin
      dir = state_i[node];
      way_o[LVL-1-l] = dir;
      node = 2 * node + 1 + int'(dir);
    end
  end

endmodule

// File: rtl/victim_sel.sv
// Empty ways take precedence (lowest index first); otherwise the tree pick.
module victim_sel #(
  parameter  int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] vmask_i,
  input  logic [LVL-1:0]  tree_way_i,
  output logic [LVL-1:0]  way_o
);

  logic [LVL-1:0] empty_way;
  logic           set_full;

  always_comb begin
    empty_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vmask_i[i]) empty_way = LVL'(i);
    end
  end

  assign set_full = &vmask_i;
  assign way_o    = set_full ? tree_way_i : empty_way;

endmodule

// File: rtl/castout_buffer.sv
module castout_buffer
  import plru_pkg::*;
#(
  parameter  int BEAT_W = 64,
  parameter  int BEATS  = 4,
  parameter  int ADDR_W = 32,
  localparam int LINE_W = BEAT_W * BEATS,
  localparam int BCNT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cap_valid_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [LINE_W-1:0] cap_data_i,
  input  logic              load_done_i,
  input  logic              wb_ready_i,
  output logic              busy_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [BEAT_W-1:0] wb_data_o,
  output logic              wb_last_o
);

  cb_state_e                     st_q, st_n;
  logic                          seen_q, seen_n;
  logic [BCNT_W-1:0]             beat_q, beat_n;
  logic [BEATS-1:0][BEAT_W-1:0]  line_q;
  logic [ADDR_W-1:0]             addr_q;
  logic                          cap_en;
  logic                          beat_last;

  assign beat_last = (beat_q == BCNT_W'(BEATS - 1));

  // next state
  always_comb begin
    st_n   = st_q;
    seen_n = seen_q;
    beat_n = beat_q;
    cap_en = 1'b0;
    case (st_q)
      CB_IDLE: begin
        if (start_i) begin
          st_n   = CB_WAIT_CAP;
          seen_n = 1'b0;
          beat_n = '0;
        end
      end
      CB_WAIT_CAP: begin
        if (load_done_i) seen_n = 1'b1;
        if (cap_valid_i) begin
          cap_en = 1'b1;
          st_n   = (seen_q || load_done_i) ? CB_DRAIN : CB_WAIT_LOAD;
        end
      end
      CB_WAIT_LOAD: begin
        if (load_done_i) st_n = CB_DRAIN;
      end
      CB_DRAIN: begin
        if (wb_ready_i) begin
          beat_n = beat_q + 1'b1;
          if (beat_last) st_n = CB_IDLE;
        end
      end
      default: st_n = CB_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CB_IDLE;
      seen_q <= 1'b0;
      beat_q <= '0;
    end else begin
      st_q   <= st_n;
      seen_q <= seen_n;
      beat_q <= beat_n;
    end
  end

  // line storage, enabled on capture only
  always_ff @(posedge clk) begin
    if (cap_en) begin
      line_q <= cap_data_i;
      addr_q <= cap_addr_i;
    end
  end

  assign busy_o     = (st_q != CB_IDLE);
  assign wb_valid_o = (st_q == CB_DRAIN);
  assign wb_addr_o  = addr_q;
  assign wb_data_o  = line_q[beat_q];
  assign wb_last_o  = wb_valid_o && beat_last;

endmodule

// File: rtl/plru_castout_ctrl.sv
module plru_castout_ctrl
  import plru_pkg::*;
#(
  parameter  int WAYS   = 8,
  parameter  int SETS   = 16,
  parameter  int BEAT_W = 64,
  parameter  int BEATS  = 4,
  parameter  int ADDR_W = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [WAY_W-1:0]  acc_way,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [SET_W-1:0]  miss_set,
  input  logic [WAYS-1:0]   miss_vmask,
  input  logic [WAYS-1:0]   miss_dmask,
  output logic              vic_valid,
  output logic [WAY_W-1:0]  vic_way,
  output logic              vic_dirty,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] cap_data,
  input  logic              refill_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BEAT_W-1:0] wb_data,
  output logic              wb_last
);

  localparam int NODES = WAYS - 1;

  logic srst_n;

  rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // ---------------------------------------------------------------
  // Tree state, one entry per set
  // ---------------------------------------------------------------
  logic [SETS-1:0][NODES-1:0] tree_q;
  logic [SETS-1:0][NODES-1:0] tree_d;
  logic [SETS-1:0]            tree_en;

  logic [NODES-1:0] acc_base, acc_next;
  logic [NODES-1:0] miss_base, miss_next;
  logic [WAY_W-1:0] tree_way, sel_way;
  logic             same_set, miss_fire, sel_dirty;
  logic             pend_q, pend_n;
  logic             buf_busy;
  logic             vic_valid_q;
  logic [WAY_W-1:0] vic_way_q;
  logic             vic_dirty_q;

  assign acc_base = tree_q[acc_set];

  plru_touch #(.WAYS(WAYS)) u_touch_acc (
    .state_i (acc_base),
    .way_i   (acc_way),
    .state_o (acc_next)
  );

  // a hit in the same cycle and set is folded in before the miss is judged
  assign same_set  = acc_valid && (acc_set == miss_set);
  assign miss_base = same_set ? acc_next : tree_q[miss_set];

  plru_walk #(.WAYS(WAYS)) u_walk (
    .state_i (miss_base),
    .way_o   (tree_way)
  );

  victim_sel #(.WAYS(WAYS)) u_vsel (
    .vmask_i    (miss_vmask),
    .tree_way_i (tree_way),
    .way_o      (sel_way)
  );

  plru_touch #(.WAYS(WAYS)) u_touch_miss (
    .state_i (miss_base),
    .way_i   (sel_way),
    .state_o (miss_next)
  );

  assign sel_dirty  = miss_dmask[sel_way] && miss_vmask[sel_way];
  assign miss_ready = !pend_q && !(sel_dirty && buf_busy);
  assign miss_fire  = miss_valid && miss_ready;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic hit_acc, hit_miss;
    assign hit_acc    = acc_valid && (acc_set == SET_W'(g));
    assign hit_miss   = miss_fire && (miss_set == SET_W'(g));
    assign tree_en[g] = hit_acc || hit_miss;
    assign tree_d[g]  = hit_miss ? miss_next : acc_next;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tree_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (tree_en[s]) tree_q[s] <= tree_d[s];
      end
    end
  end

  // ---------------------------------------------------------------
  // Outstanding miss and victim report
  // ---------------------------------------------------------------
  always_comb begin
    pend_n = pend_q;
    if (miss_fire)        pend_n = 1'b1;
    else if (refill_done) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q      <= 1'b0;
      vic_valid_q <= 1'b0;
      vic_way_q   <= '0;
      vic_dirty_q <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      vic_valid_q <= miss_fire;
      if (miss_fire) begin
        vic_way_q   <= sel_way;
        vic_dirty_q <= sel_dirty;
      end
    end
  end

  assign vic_valid = vic_valid_q;
  assign vic_way   = vic_way_q;
  assign vic_dirty = vic_dirty_q;

  // ---------------------------------------------------------------
  // Castout buffer
  // ---------------------------------------------------------------
  castout_buffer #(
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS),
    .ADDR_W (ADDR_W)
  ) u_cbuf (
    .clk         (clk),
    .rst_n       (srst_n),
    .start_i     (miss_fire && sel_dirty),
    .cap_valid_i (cap_valid),
    .cap_addr_i  (cap_addr),
    .cap_data_i  (cap_data),
    .load_done_i (refill_done && pend_q),
    .wb_ready_i  (wb_ready),
    .busy_o      (buf_busy),
    .wb_valid_o  (wb_valid),
    .wb_addr_o   (wb_addr),
    .wb_data_o   (wb_data),
    .wb_last_o   (wb_last)
  );

endmodule

// File: rtl/plru_castout_chk.sv
module plru_castout_chk #(
  parameter  int WAYS   = 8,
  parameter  int BEAT_W = 64,
  parameter  int ADDR_W = 32,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [WAYS-1:0]   miss_vmask,
  input logic              vic_valid,
  input logic [WAY_W-1:0]  vic_way,
  input logic              vic_dirty,
  input logic              cap_valid,
  input logic              refill_done,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [BEAT_W-1:0] wb_data,
  input logic              wb_last,
  input logic              pend_q,
  input logic              buf_busy
);

  logic [WAYS-1:0] vmask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask_q <= '0;
    end else if (miss_valid && miss_ready) begin
      vmask_q <= miss_vmask;
    end
  end

  // R5
  vic_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> vic_valid);

  // R3
  empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !(&vmask_q)) |-> !vmask_q[vic_way]);

  // R11
  single_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !miss_ready);

  // R10
  no_second_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && buf_busy) |=> !vic_dirty);

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr) && $stable(wb_last)));

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && wb_last) |=> !wb_valid);

  // R7
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> ($past(refill_done) || $past(cap_valid)));

endmodule

bind plru_castout_ctrl plru_castout_chk #(
  .WAYS   (WAYS),
  .BEAT_W (BEAT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .miss_ready  (miss_ready),
  .miss_vmask  (miss_vmask),
  .vic_valid   (vic_valid),
  .vic_way     (vic_way),
  .vic_dirty   (vic_dirty),
  .cap_valid   (cap_valid),
  .refill_done (refill_done),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .wb_last     (wb_last),
  .pend_q      (pend_q),
  .buf_busy    (buf_busy)
);

// File: tb/sim_plru_castout_ctrl.sv
module sim_plru_castout_ctrl;

  logic         clk;
  logic         rst_n;
  logic         acc_valid;
  logic [3:0]   acc_set;
  logic [2:0]   acc_way;
  logic         miss_valid;
  logic         miss_ready;
  logic [3:0]   miss_set;
  logic [7:0]   miss_vmask;
  logic [7:0]   miss_dmask;
  logic         vic_valid;
  logic [2:0]   vic_way;
  logic         vic_dirty;
  logic         cap_valid;
  logic [31:0]  cap_addr;
  logic [255:0] cap_data;
  logic         refill_done;
  logic         wb_valid;
  logic         wb_ready;
  logic [31:0]  wb_addr;
  logic [63:0]  wb_data;
  logic         wb_last;

  int n_tests;
  int n_fail;

  logic [6:0] mdl [16];

  plru_castout_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_set     (acc_set),
    .acc_way     (acc_way),
    .miss_valid  (miss_valid),
    .miss_ready  (miss_ready),
    .miss_set    (miss_set),
    .miss_vmask  (miss_vmask),
    .miss_dmask  (miss_dmask),
    .vic_valid   (vic_valid),
    .vic_way     (vic_way),
    .vic_dirty   (vic_dirty),
    .cap_valid   (cap_valid),
    .cap_addr    (cap_addr),
    .cap_data    (cap_data),
    .refill_done (refill_done),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data),
    .wb_last     (wb_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model of the replacement order ----------------
  function automatic void mtouch(input int s, input int w);
    mdl[s][0]         = (w < 4);
    mdl[s][1 + w / 4] = ((w % 4) < 2);
    mdl[s][3 + w / 2] = ((w % 2) == 0);
  endfunction

  function automatic int mvict(input int s);
    int b0, b1, b2;
    b0 = int'(mdl[s][0]);
    b1 = int'(mdl[s][b0 ? 2 : 1]);
    b2 = int'(mdl[s][3 + 2 * b0 + b1]);
    return 4 * b0 + 2 * b1 + b2;
  endfunction

  function automatic int mpick(input int s, input logic [7:0] vm);
    for (int i = 0; i < 8; i++) begin
      if (!vm[i]) return i;
    end
    return mvict(s);
  endfunction

  function automatic logic [255:0] mkline(input logic [63:0] base);
    return {base + 64'd3, base + 64'd2, base + 64'd1, base};
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic miss_req(input int s, input logic [7:0] vm, input logic [7:0] dm);
    int    ew;
    logic  ed;
    string tg;
    ew = mpick(s, vm);
    ed = dm[ew] & vm[ew];
    tg = (&vm) ? "R4" : "R3";
    @(negedge clk);
    miss_valid = 1'b1;
    miss_set   = 4'(s);
    miss_vmask = vm;
    miss_dmask = dm;
    #1;
    chk("R11", "miss_ready when nothing outstanding", miss_ready, 1);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R5", "vic_valid after accept", vic_valid, 1);
    chk(tg, "vic_way", vic_way, ew);
    chk("R6", "vic_dirty", vic_dirty, ed);
    mtouch(s, ew);
  endtask

  task automatic access(input int s, input int w);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_set   = 4'(s);
    acc_way   = 3'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    mtouch(s, w);
  endtask

  task automatic refill();
    @(negedge clk);
    refill_done = 1'b1;
    @(negedge clk);
    refill_done = 1'b0;
  endtask

  // called at a falling edge
  task automatic capture(input logic [31:0] a, input logic [255:0] d);
    cap_valid = 1'b1;
    cap_addr  = a;
    cap_data  = d;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic quiet_wb(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(tag, "wb_valid must stay low", wb_valid, 0);
    end
  endtask

  task automatic drain_check(input logic [31:0] a, input logic [255:0] line, input logic [7:0] pat);
    int beat;
    int cyc;
    beat = 0;
    cyc  = 0;
    while (beat < 4 && cyc < 64) begin
      @(negedge clk);
      chk("R7", "wb_valid during drain", wb_valid, 1);
      wb_ready = pat[cyc % 8];
      if (wb_valid) begin
        chk("R8", "beat data", wb_data, line[beat*64 +: 64]);
        chk("R8", "beat address", wb_addr, a);
        chk("R8", "wb_last", wb_last, (beat == 3));
        if (wb_ready) beat++;
      end
      cyc++;
    end
    chk("R8", "beats transferred", beat, 4);
    @(negedge clk);
    wb_ready = 1'b0;
    chk("R8", "wb_valid after last beat", wb_valid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "miss_ready after reset", miss_ready, 1);
    chk("R1", "wb_valid after reset", wb_valid, 0);
    chk("R1", "vic_valid after reset", vic_valid, 0);
    miss_req(0, 8'hFF, 8'h00);
    chk("R1", "first victim of full set", vic_way, 0);
    refill();
    chk("R5", "vic_valid is a single pulse", vic_valid, 0);
  endtask

  task automatic t_access_order();
    for (int w = 0; w < 8; w++) access(2, w);
    miss_req(2, 8'hFF, 8'h00);
    chk("R2", "victim after ascending accesses", vic_way, 0);
    refill();
    access(2, 5);
    access(2, 2);
    access(2, 7);
    miss_req(2, 8'hFF, 8'h00);
    refill();
    miss_req(2, 8'hFF, 8'h00);
    refill();
  endtask

  task automatic t_empty_ways();
    access(1, 1);
    miss_req(1, 8'b1111_0101, 8'h00);
    chk("R3", "lowest empty way", vic_way, 1);
    refill();
    miss_req(1, 8'h7F, 8'h00);
    chk("R3", "only empty way is 7", vic_way, 7);
    refill();
    miss_req(1, 8'hFE, 8'hFF);
    chk("R6", "empty way never dirty", vic_dirty, 0);
    refill();
  endtask

  task automatic t_sets();
    for (int w = 0; w < 4; w++) access(4, w);
    miss_req(5, 8'hFF, 8'h00);
    chk("R12", "untouched set keeps way 0", vic_way, 0);
    refill();
    miss_req(4, 8'hFF, 8'h00);
    chk("R12", "touched set moves to upper half", vic_way, 4);
    refill();
  endtask

  task automatic t_dirty();
    logic [255:0] ln;
    ln = mkline(64'hA5A5_0000_1000_0000);
    miss_req(6, 8'hFF, 8'hFF);
    capture(32'h0000_6C00, ln);
    quiet_wb(4, "R7");
    refill();
    drain_check(32'h0000_6C00, ln, 8'b1011_0110);
  endtask

  task automatic t_refill_first();
    logic [255:0] ln;
    ln = mkline(64'h3C3C_0000_2000_0000);
    miss_req(9, 8'hFF, 8'hFF);
    refill();
    quiet_wb(3, "R7");
    capture(32'h0001_9A40, ln);
    drain_check(32'h0001_9A40, ln, 8'hFF);
  endtask

  task automatic t_clean();
    logic [255:0] ln;
    ln = mkline(64'h7E7E_0000_3000_0000);
    capture(32'hDEAD_0000, mkline(64'hBAD0_BAD0_0000_0000));
    miss_req(10, 8'hFF, 8'hFE);
    chk("R9", "victim reported clean", vic_dirty, 0);
    capture(32'hDEAD_1000, mkline(64'hBAD1_BAD1_0000_0000));
    refill();
    quiet_wb(5, "R9");
    miss_req(10, 8'hFF, 8'hFF);
    capture(32'h0002_0A80, ln);
    refill();
    drain_check(32'h0002_0A80, ln, 8'b0110_1101);
  endtask

  task automatic t_stall();
    logic [255:0] l1, l2;
    int           ew;
    l1 = mkline(64'h1111_0000_4000_0000);
    l2 = mkline(64'h2222_0000_5000_0000);
    wb_ready = 1'b0;
    miss_req(11, 8'hFF, 8'hFF);
    capture(32'h0003_0B00, l1);
    refill();
    // buffer draining and back-pressured: dirty miss must wait
    @(negedge clk);
    miss_valid = 1'b1;
    miss_set   = 4'd12;
    miss_vmask = 8'hFF;
    miss_dmask = 8'hFF;
    #1;
    chk("R10", "dirty miss stalls while buffer busy", miss_ready, 0);
    miss_dmask = 8'h00;
    #1;
    chk("R10", "clean miss passes while buffer busy", miss_ready, 1);
    ew = mpick(12, 8'hFF);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R10", "clean miss victim way", vic_way, ew);
    chk("R10", "clean miss victim not dirty", vic_dirty, 0);
    mtouch(12, ew);
    // a second miss while one is outstanding
    miss_valid = 1'b1;
    miss_set   = 4'd13;
    miss_vmask = 8'hFF;
    miss_dmask = 8'h00;
    #1;
    chk("R11", "second miss held while refill pending", miss_ready, 0);
    miss_valid = 1'b0;
    refill();
    miss_valid = 1'b1;
    miss_dmask = 8'hFF;
    #1;
    chk("R10", "dirty miss still held until drain ends", miss_ready, 0);
    miss_valid = 1'b0;
    drain_check(32'h0003_0B00, l1, 8'b0101_0101);
    miss_req(13, 8'hFF, 8'hFF);
    capture(32'h0003_0D40, l2);
    refill();
    drain_check(32'h0003_0D40, l2, 8'hFF);
  endtask

  // ---------------- run ----------------
  initial begin : main
    n_tests     = 0;
    n_fail      = 0;
    rst_n       = 1'b0;
    acc_valid   = 1'b0;
    acc_set     = '0;
    acc_way     = '0;
    miss_valid  = 1'b0;
    miss_set    = '0;
    miss_vmask  = '0;
    miss_dmask  = '0;
    cap_valid   = 1'b0;
    cap_addr    = '0;
    cap_data    = '0;
    refill_done = 1'b0;
    wb_ready    = 1'b0;
    for (int s = 0; s < 16; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    t_reset();
    t_access_order();
    t_empty_ways();
    t_sets();
    t_dirty();
    t_refill_first();
    t_clean();
    t_stall();

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule